// File: doc/BRIEF.md
# Replay-Aware Reorder Buffer

This block is the in-order retirement stage of a small out-of-order core. Each dispatched instruction gets the next free slot of a circular buffer, and the block returns that slot index to the dispatcher. Execution units later report completion against the index, in any order. Retirement happens one entry per cycle, and only from the oldest slot. A store that retires is released to the store buffer at that point, and only then does its data reach the shared cache.

A load that turns out to have read memory ahead of an older store to the same address is not removed. The violation port names that load and supplies a bit mask of the entries that consumed its result. The block keeps all of them allocated and withdraws their ready status, so retirement stops at the first such entry until the replayed work completes again.

A fault reported with a completion is only noted. It becomes an exception when the faulting entry is the oldest one. At that point the whole buffer is discarded and a one-cycle flush pulse is raised. A replaying load and a retiring store share a single cache port, and a small arbiter settles the contention between them.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1 and `commit_valid_o`, `exc_o` and `flush_o` are 0.
- R2: Dispatched entries receive consecutive indices, wrapping modulo DEPTH and starting at 0 after reset. Once DEPTH entries are outstanding, `disp_ready_o` is 0 and dispatch is refused.
- R3: A completion marks the addressed entry ready whatever its age. A ready younger entry does not retire while the oldest entry is not ready.
- R4: At most one entry retires per cycle, in allocation order, and `commit_idx_o` gives its index. A retired slot becomes free: once the buffer drains, `disp_ready_o` is 1 again.
- R5: A store entry retires with `commit_store_o` = 1 in the cycle after its completion is recorded, provided it is the oldest entry and the cache port is free.
- R6: A violation on index i leaves entry i and every entry whose bit is set in `viol_dep_mask_i` allocated, but not ready. None of them retires until a new completion is reported for it.
- R7: A completion with `cmpl_fault_i` = 1 raises nothing while older entries remain. When the entry is oldest, `exc_o` and `flush_o` are 1 for exactly one cycle, `exc_idx_o` names the entry, it does not retire, and `disp_ready_o` is 0. Afterwards the buffer is empty and the next dispatch receives index 0.
- R8: When a retiring store at the head and `replay_req_i` meet on a free port in the same cycle, the store retires and `replay_gnt_o` is 0. The replay is granted on a later free cycle.
- R9: A granted replay holds the cache port for REPLAY_CYC cycles (default 2). A store at the head does not retire during that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_store_i | input | 1 | Dispatched instruction is a store |
| disp_ready_o | output | 1 | Dispatch will be accepted this cycle |
| disp_idx_o | output | IW | Index given to the dispatched entry |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_idx_i | input | IW | Entry that completed |
| cmpl_fault_i | input | 1 | Completion carries a fault |
| viol_valid_i | input | 1 | Ordering violation report |
| viol_idx_i | input | IW | Load entry that violated |
| viol_dep_mask_i | input | DEPTH | Entries dependent on that load |
| replay_req_i | input | 1 | Replaying load requests the cache port |
| replay_gnt_o | output | 1 | Cache port granted to the replay |
| commit_valid_o | output | 1 | Head entry retires this cycle |
| commit_idx_o | output | IW | Index of the retiring entry |
| commit_store_o | output | 1 | Retiring entry is a store, released to the store buffer |
| exc_o | output | 1 | Exception taken at the head |
| exc_idx_o | output | IW | Entry that raised the exception |
| flush_o | output | 1 | Whole buffer discarded this cycle |

## Verification
Two pairs of events can land in the same cycle. The first pair is a store that becomes eligible at the head and a replay request. The bench sends the store's completion one cycle ahead and raises `replay_req_i` in the cycle the store becomes eligible. It then requires the store to retire with the grant withheld, and the replay to be granted in the next cycle. The second pair is a completion and a replay grant in the same cycle. The bench expects the store to wait out the port hold, and it judges this from `commit_valid_o` in each of the following two cycles.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  typedef struct packed {
    logic valid;
    logic ready;
    logic fault;
    logic store;
  } rob_flags_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     clear_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic [$clog2(DEPTH)-1:0] tail_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int IW = $clog2(DEPTH);

  // extra MSB tells full from empty
  logic [IW:0] head_q, tail_q;
  logic [IW:0] occ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
    end
  end

  assign head_o  = head_q[IW-1:0];
  assign tail_o  = tail_q[IW-1:0];
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[IW-1:0] == tail_q[IW-1:0]) && (head_q[IW] != tail_q[IW]);
  assign occ     = tail_q - head_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R2
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= (IW+1)'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R4
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import reorder_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     alloc_i,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx_i,
  input  logic                     alloc_store_i,
  input  logic                     retire_i,
  input  logic [$clog2(DEPTH)-1:0] retire_idx_i,
  input  logic                     cmpl_i,
  input  logic [$clog2(DEPTH)-1:0] cmpl_idx_i,
  input  logic                     cmpl_fault_i,
  input  logic                     viol_i,
  input  logic [$clog2(DEPTH)-1:0] viol_idx_i,
  input  logic [DEPTH-1:0]         viol_mask_i,
  output logic [DEPTH-1:0]         valid_o,
  output logic [DEPTH-1:0]         ready_o,
  output logic [DEPTH-1:0]         fault_o,
  output logic [DEPTH-1:0]         store_o
);
  localparam int IW = $clog2(DEPTH);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    rob_flags_t ent_q;
    logic is_alloc, is_retire, is_cmpl, is_viol;

    assign is_alloc  = alloc_i  && (alloc_idx_i  == IW'(e));
    assign is_retire = retire_i && (retire_idx_i == IW'(e));
    // completions for free slots are dropped
    assign is_cmpl   = cmpl_i   && (cmpl_idx_i   == IW'(e)) && ent_q.valid;
    assign is_viol   = viol_i   && ((viol_idx_i == IW'(e)) || viol_mask_i[e]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (clear_i) begin
        ent_q <= '0;
      end else if (is_alloc) begin
        ent_q <= '{valid: 1'b1, ready: 1'b0, fault: 1'b0, store: alloc_store_i};
      end else begin
        if (is_retire) ent_q.valid <= 1'b0;
        if (is_cmpl) begin
          ent_q.ready <= 1'b1;
          ent_q.fault <= cmpl_fault_i;
        end
        // violation beats a same-cycle completion; replay re-executes
        if (is_viol) begin
          ent_q.ready <= 1'b0;
          ent_q.fault <= 1'b0;
        end
      end
    end

    assign valid_o[e] = ent_q.valid;
    assign ready_o[e] = ent_q.ready;
    assign fault_o[e] = ent_q.fault;
    assign store_o[e] = ent_q.store;
  end

  AST_VIOL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_i && valid_o[viol_idx_i] && !clear_i)
    |=> (valid_o[$past(viol_idx_i)] && !ready_o[$past(viol_idx_i)])); // R6
  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_o[alloc_idx_i]); // R2
endmodule

// File: rtl/rob_port_arb.sv
module rob_port_arb #(
  parameter int REPLAY_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_req_i,
  input  logic replay_req_i,
  output logic store_gnt_o,
  output logic replay_gnt_o
);
  localparam int CW = $clog2(REPLAY_CYC + 1);

  logic [CW-1:0] busy_q;
  logic          port_free;

  assign port_free    = (busy_q == '0);
  // retirement first, so replays cannot starve the head
  assign store_gnt_o  = store_req_i && port_free;
  assign replay_gnt_o = replay_req_i && port_free && !store_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_q <= '0;
    else if (replay_gnt_o) busy_q <= CW'(REPLAY_CYC - 1);
    else if (!port_free)   busy_q <= busy_q - 1'b1;
  end

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_gnt_o && replay_gnt_o)); // R8
  AST_STORE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_i && replay_req_i && store_gnt_o) |-> !replay_gnt_o); // R8

  if (REPLAY_CYC > 1) begin : g_hold
    AST_REPLAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      replay_gnt_o |=> (!store_gnt_o && !replay_gnt_o)); // R9
  end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int REPLAY_CYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     disp_valid_i,
  input  logic                     disp_store_i,
  output logic                     disp_ready_o,
  output logic [$clog2(DEPTH)-1:0] disp_idx_o,
  input  logic                     cmpl_valid_i,
  input  logic [$clog2(DEPTH)-1:0] cmpl_idx_i,
  input  logic                     cmpl_fault_i,
  input  logic                     viol_valid_i,
  input  logic [$clog2(DEPTH)-1:0] viol_idx_i,
  input  logic [DEPTH-1:0]         viol_dep_mask_i,
  input  logic                     replay_req_i,
  output logic                     replay_gnt_o,
  output logic                     commit_valid_o,
  output logic [$clog2(DEPTH)-1:0] commit_idx_o,
  output logic                     commit_store_o,
  output logic                     exc_o,
  output logic [$clog2(DEPTH)-1:0] exc_idx_o,
  output logic                     flush_o
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0]    head_idx, tail_idx;
  logic             full, empty;
  logic [DEPTH-1:0] valid_v, ready_v, fault_v, store_v;
  logic             head_viol, head_live, take_exc;
  logic             store_req, store_gnt, do_commit, do_disp;

  // a violation landing on the head this cycle blocks its retirement
  assign head_viol = viol_valid_i && ((viol_idx_i == head_idx) || viol_dep_mask_i[head_idx]);
  assign head_live = valid_v[head_idx] && ready_v[head_idx] && !head_viol;
  assign take_exc  = head_live && fault_v[head_idx];
  assign store_req = head_live && !fault_v[head_idx] && store_v[head_idx];
  assign do_commit = head_live && !fault_v[head_idx] && (!store_v[head_idx] || store_gnt);
  assign do_disp   = disp_valid_i && disp_ready_o;

  assign disp_ready_o   = !full && !take_exc;
  assign disp_idx_o     = tail_idx;
  assign commit_valid_o = do_commit;
  assign commit_idx_o   = head_idx;
  assign commit_store_o = do_commit && store_v[head_idx];
  assign exc_o          = take_exc;
  assign exc_idx_o      = head_idx;
  assign flush_o        = take_exc;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_disp),
    .pop_i   (do_commit),
    .clear_i (take_exc),
    .head_o  (head_idx),
    .tail_o  (tail_idx),
    .full_o  (full),
    .empty_o (empty)
  );

  rob_entries #(.DEPTH(DEPTH)) u_entries (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (take_exc),
    .alloc_i       (do_disp),
    .alloc_idx_i   (tail_idx),
    .alloc_store_i (disp_store_i),
    .retire_i      (do_commit),
    .retire_idx_i  (head_idx),
    .cmpl_i        (cmpl_valid_i),
    .cmpl_idx_i    (cmpl_idx_i),
    .cmpl_fault_i  (cmpl_fault_i),
    .viol_i        (viol_valid_i),
    .viol_idx_i    (viol_idx_i),
    .viol_mask_i   (viol_dep_mask_i),
    .valid_o       (valid_v),
    .ready_o       (ready_v),
    .fault_o       (fault_v),
    .store_o       (store_v)
  );

  rob_port_arb #(.REPLAY_CYC(REPLAY_CYC)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .store_req_i  (store_req),
    .replay_req_i (replay_req_i),
    .store_gnt_o  (store_gnt),
    .replay_gnt_o (replay_gnt_o)
  );

  AST_RETIRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> !valid_v[$past(commit_idx_o)]); // R4
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !commit_valid_o && !exc_o); // R4
  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (valid_v == '0)); // R7
  AST_EXC_NOT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_o && commit_valid_o)); // R7
endmodule

// File: tb/tb_reorder_buf.sv
module tb_reorder_buf;
  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic             disp_valid_i, disp_store_i, disp_ready_o;
  logic [IW-1:0]    disp_idx_o;
  logic             cmpl_valid_i, cmpl_fault_i;
  logic [IW-1:0]    cmpl_idx_i;
  logic             viol_valid_i;
  logic [IW-1:0]    viol_idx_i;
  logic [DEPTH-1:0] viol_dep_mask_i;
  logic             replay_req_i, replay_gnt_o;
  logic             commit_valid_o, commit_store_o;
  logic [IW-1:0]    commit_idx_o;
  logic             exc_o, flush_o;
  logic [IW-1:0]    exc_idx_o;

  reorder_buf #(.DEPTH(DEPTH), .REPLAY_CYC(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_store_i(disp_store_i),
    .disp_ready_o(disp_ready_o), .disp_idx_o(disp_idx_o),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_idx_i(cmpl_idx_i), .cmpl_fault_i(cmpl_fault_i),
    .viol_valid_i(viol_valid_i), .viol_idx_i(viol_idx_i), .viol_dep_mask_i(viol_dep_mask_i),
    .replay_req_i(replay_req_i), .replay_gnt_o(replay_gnt_o),
    .commit_valid_o(commit_valid_o), .commit_idx_o(commit_idx_o), .commit_store_o(commit_store_o),
    .exc_o(exc_o), .exc_idx_o(exc_idx_o), .flush_o(flush_o)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  int  tail = 0;
  bit  done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid_i = 0; disp_store_i = 0;
    cmpl_valid_i = 0; cmpl_idx_i = '0; cmpl_fault_i = 0;
    viol_valid_i = 0; viol_idx_i = '0; viol_dep_mask_i = '0;
    replay_req_i = 0;
  endtask

  function automatic logic [IW-1:0] ix(input int n);
    return IW'(n % DEPTH);
  endfunction

  task automatic do_disp(input string req, input bit st);
    disp_valid_i = 1; disp_store_i = st; #1;
    check(req, int'(disp_idx_o), tail % DEPTH);
    @(negedge clk);
    disp_valid_i = 0; disp_store_i = 0;
    tail++;
  endtask

  task automatic do_cmpl(input logic [IW-1:0] idx, input bit flt);
    cmpl_valid_i = 1; cmpl_idx_i = idx; cmpl_fault_i = flt;
    @(negedge clk);
    cmpl_valid_i = 0; cmpl_fault_i = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 disp_ready", int'(disp_ready_o), 1);
    check("R1 commit_valid", int'(commit_valid_o), 0);
    check("R1 exc", int'(exc_o), 0);
    check("R1 flush", int'(flush_o), 0);
  endtask

  task automatic t_fill_drain();
    int order [7] = '{3, 5, 7, 1, 2, 4, 6};
    for (int i = 0; i < DEPTH; i++) do_disp("R2 dispatch index", 1'b0);
    #1 check("R2 refused when full", int'(disp_ready_o), 0);
    foreach (order[k]) begin
      do_cmpl(ix(order[k]), 1'b0);
      #1 check("R3 younger waits", int'(commit_valid_o), 0);
    end
    do_cmpl(ix(0), 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      check("R4 commit one per cycle", int'(commit_valid_o), 1);
      check("R4 commit order", int'(commit_idx_o), i);
      @(negedge clk);
    end
    #1;
    check("R4 drained", int'(commit_valid_o), 0);
    check("R4 slots freed", int'(disp_ready_o), 1);
  endtask

  task automatic t_violation();
    int a = tail;
    do_disp("R6 dispatch", 1'b0);
    do_disp("R6 dispatch", 1'b0);
    do_disp("R6 dispatch", 1'b0);
    do_cmpl(ix(a+1), 1'b0);
    do_cmpl(ix(a+2), 1'b0);
    viol_valid_i = 1; viol_idx_i = ix(a+1);
    viol_dep_mask_i = '0; viol_dep_mask_i[ix(a+2)] = 1'b1;
    @(negedge clk);
    viol_valid_i = 0; viol_dep_mask_i = '0;
    do_cmpl(ix(a), 1'b0);
    #1;
    check("R6 head retires", int'(commit_valid_o), 1);
    check("R6 head index", int'(commit_idx_o), a % DEPTH);
    @(negedge clk);
    #1 check("R6 violating load held", int'(commit_valid_o), 0);
    do_cmpl(ix(a+1), 1'b0);
    #1;
    check("R6 replayed load retires", int'(commit_valid_o), 1);
    check("R6 replayed index", int'(commit_idx_o), (a+1) % DEPTH);
    @(negedge clk);
    #1 check("R6 dependent held", int'(commit_valid_o), 0);
    do_cmpl(ix(a+2), 1'b0);
    #1 check("R6 dependent retires", int'(commit_idx_o), (a+2) % DEPTH);
    @(negedge clk);
  endtask

  task automatic t_store();
    int s = tail;
    do_disp("R5 dispatch", 1'b1);
    do_cmpl(ix(s), 1'b0);
    #1;
    check("R5 store commit", int'(commit_valid_o), 1);
    check("R5 store flag", int'(commit_store_o), 1);
    check("R5 store index", int'(commit_idx_o), s % DEPTH);
    @(negedge clk);
  endtask

  task automatic t_arb();
    int s = tail;
    do_disp("R8 dispatch", 1'b1);
    do_cmpl(ix(s), 1'b0);
    replay_req_i = 1; #1;
    check("R8 store wins", int'(commit_store_o), 1);
    check("R8 replay refused", int'(replay_gnt_o), 0);
    @(negedge clk);
    #1 check("R8 replay served next", int'(replay_gnt_o), 1);
    @(negedge clk);
    replay_req_i = 0;
  endtask

  task automatic t_replay_hold();
    int s = tail;
    do_disp("R9 dispatch", 1'b1);
    cmpl_valid_i = 1; cmpl_idx_i = ix(s); replay_req_i = 1; #1;
    check("R9 replay granted", int'(replay_gnt_o), 1);
    @(negedge clk);
    cmpl_valid_i = 0; replay_req_i = 0; #1;
    check("R9 store stalled by replay", int'(commit_valid_o), 0);
    @(negedge clk);
    #1;
    check("R9 store after hold", int'(commit_valid_o), 1);
    check("R9 store flag", int'(commit_store_o), 1);
    @(negedge clk);
  endtask

  task automatic t_fault();
    int a = tail;
    do_disp("R7 dispatch", 1'b0);
    do_disp("R7 dispatch", 1'b0);
    do_cmpl(ix(a+1), 1'b1);
    #1;
    check("R7 fault deferred", int'(exc_o), 0);
    check("R7 no flush early", int'(flush_o), 0);
    do_cmpl(ix(a), 1'b0);
    #1;
    check("R7 older retires", int'(commit_valid_o), 1);
    check("R7 still deferred", int'(exc_o), 0);
    @(negedge clk);
    #1;
    check("R7 exception", int'(exc_o), 1);
    check("R7 flush", int'(flush_o), 1);
    check("R7 exc index", int'(exc_idx_o), (a+1) % DEPTH);
    check("R7 faulting not retired", int'(commit_valid_o), 0);
    check("R7 dispatch blocked", int'(disp_ready_o), 0);
    @(negedge clk);
    #1;
    check("R7 flush one cycle", int'(flush_o), 0);
    check("R7 exc one cycle", int'(exc_o), 0);
    tail = 0;
    do_disp("R7 index reset", 1'b0);
    do_cmpl(ix(0), 1'b0);
    @(negedge clk);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    @(negedge clk);
    t_fill_drain();
    t_violation();
    t_store();
    t_arb();
    t_replay_hold();
    t_fault();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule